// File: doc/BRIEF.md
# Indexed Byte Access Port with Lockable Windows

This block is an I/O front end that gives a narrow register port access to a byte-addressed memory. The port has four offsets. Software first builds a 16-bit pointer by writing its two halves through two of them, and then moves a byte through the data offset. A store through the data offset writes the byte at the pointer and then returns the pointer to zero. A read through the data offset returns the byte at the pointer one cycle later and leaves the pointer unchanged.

Two fixed 16-byte windows in the low part of the address space can each be sealed. A sealed window rejects stores, and its bytes read back as all ones. Each seal flips when a single-cycle toggle request arrives. It cannot be set or cleared directly. Pointers that fall outside the configured memory size behave in the same way: stores are dropped, and reads return all ones. The storage is a behavioural byte array whose size is a parameter. Reset clears the pointer and both seals, and leaves the stored bytes untouched.

Top module: `idx_byte_port`

## Requirements
- R1: A write with `port_sel`=0 replaces bits 7:0 of the pointer, and a write with `port_sel`=1 replaces bits 15:8. In both cases the other half keeps its value.
- R2: A write with `port_sel`=3 stores `wr_data` at the pointer and clears the pointer to 0x0000. The clear happens even when the store itself is dropped.
- R3: A read with `port_sel`=3 drives the byte at the pointer on `rd_data` in the cycle after the strobe. The read does not change the pointer. Without a read strobe, `rd_data` holds its value.
- R4: Seal bit 0 covers addresses 0x20 to 0x2F, and seal bit 1 covers addresses 0x30 to 0x3F. A store into a sealed window is dropped, and a read from it returns 0xFF. Bytes outside the sealed window are unaffected.
- R5: Each clock cycle in which `lock_toggle[i]` is high flips seal bit i. A second pulse therefore unseals the window again.
- R6: A pointer at or above `MEM_BYTES` (default 1024) stores nothing and does not alias onto a lower byte. A read at such a pointer returns 0xFF.
- R7: A write with `port_sel`=2 is ignored, and leaves both the pointer and the memory unchanged. A read with `port_sel` equal to 0, 1 or 2 returns 0xFF.
- R8: Reset clears the pointer and both seals and drives `rd_data` to 0xFF. Bytes held in memory survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 2 | Port offset: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Byte written to the selected offset |
| rd_en | input | 1 | Read strobe, one cycle per access, never together with wr_en |
| lock_toggle | input | 2 | Per-window seal toggle request |
| rd_data | output | 8 | Registered read byte, valid the cycle after rd_en |

## Verification
A pointer half loaded wrongly shows up on the next data read as a byte taken from the wrong address. A pointer that fails to clear after a store shows up when the bench reads through the data offset straight away and expects the byte at address zero. A wrong seal bit, or a window with the wrong bounds, appears one cycle after the first read of a byte inside the window or beside it. A dropped store that leaks into memory, or a pointer that aliases past the memory size, stays hidden until that byte is read back. For that reason every ignored write is followed by a read-back of the location it could have reached.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
   typedef enum logic [1:0] {
      SEL_PTR_LO = 2'd0,
      SEL_PTR_HI = 2'd1,
      SEL_SPARE  = 2'd2,
      SEL_DATA   = 2'd3
   } port_sel_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/ibp_ptr_latch.sv
module ibp_ptr_latch #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_lo,
   input  logic              load_hi,
   input  logic              clear,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] ptr_q
);
   initial begin
      assert (ADDR_W == 2 * DATA_W) else $error("pointer must be two data bytes wide");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clear) begin
         ptr_q <= '0;
      end else if (load_lo) begin
         ptr_q[DATA_W-1:0] <= din;
      end else if (load_hi) begin
         ptr_q[ADDR_W-1:DATA_W] <= din;
      end
   end

   // R2: a store clears the pointer
   p_clear_after_store_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ptr_q == '0));
   // R1: low half load keeps the high half
   p_lo_load_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (load_lo && !clear) |=> (ptr_q[DATA_W-1:0] == $past(din)) &&
                              (ptr_q[ADDR_W-1:DATA_W] == $past(ptr_q[ADDR_W-1:DATA_W])));
endmodule

// File: rtl/ibp_lock_ctrl.sv
module ibp_lock_ctrl #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_LOCKS = 2,
   parameter int unsigned LOCK_BASE = 32,
   parameter int unsigned WIN_BYTES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOCKS-1:0] toggle,
   input  logic [ADDR_W-1:0]    ptr,
   output logic [NUM_LOCKS-1:0] lock_q,
   output logic                 sealed_hit
);
   localparam int unsigned TOP = LOCK_BASE + NUM_LOCKS * WIN_BYTES;

   initial begin
      assert (NUM_LOCKS >= 1) else $error("need at least one window");
      assert (TOP <= (1 << ADDR_W)) else $error("windows exceed address space");
   end

   logic [NUM_LOCKS-1:0] in_win;
   logic [31:0]          ptr32;

   assign ptr32 = 32'(ptr);

   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
      localparam int unsigned LO = LOCK_BASE + i * WIN_BYTES;
      localparam int unsigned HI = LO + WIN_BYTES;
      assign in_win[i] = (ptr32 >= LO) && (ptr32 < HI);
   end

   assign sealed_hit = |(in_win & lock_q);

   always_ff @(posedge clk) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= lock_q ^ toggle;
   end

   // R5: seals change only on a toggle request
   p_lock_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (toggle == '0) |=> $stable(lock_q));
   p_lock_flip_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      toggle[0] |=> (lock_q[0] != $past(lock_q[0])));
endmodule

// File: rtl/ibp_byte_store.sv
module ibp_byte_store #(
   parameter int unsigned MEM_BYTES = 1024,
   parameter int unsigned DATA_W    = 8,
   localparam int unsigned IDX_W    = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata_q
);
   logic [DATA_W-1:0] mem [MEM_BYTES];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
      if (re) rdata_q <= mem[idx];
   end
endmodule

// File: rtl/idx_byte_port.sv
module idx_byte_port #(
   parameter int unsigned MEM_BYTES = 1024,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_LOCKS = 2,
   parameter int unsigned LOCK_BASE = 32,
   parameter int unsigned WIN_BYTES = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  port_sel,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   input  logic        rd_en,
   input  logic [1:0]  lock_toggle,
   output logic [7:0]  rd_data
);
   import ibp_pkg::*;

   localparam int unsigned IDX_W = $clog2(MEM_BYTES);
   localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W + 1)'(MEM_BYTES);

   initial begin
      assert (DATA_W == BYTE_W) else $error("data path is one byte");
      assert (MEM_BYTES >= 2 && MEM_BYTES <= (1 << ADDR_W)) else $error("bad memory size");
      assert (NUM_LOCKS == 2) else $error("toggle port carries two windows");
   end

   logic [ADDR_W-1:0]    ptr_q;
   logic [NUM_LOCKS-1:0] lock_q;
   logic                 sealed_hit;
   logic                 mapped;
   logic                 data_wr, data_rd;
   logic                 blank_q;
   logic [DATA_W-1:0]    store_q;

   assign data_wr = wr_en && (port_sel == SEL_DATA);
   assign data_rd = rd_en && (port_sel == SEL_DATA);

   if (MEM_BYTES == (1 << ADDR_W)) begin : g_full_map
      assign mapped = 1'b1;
   end else begin : g_part_map
      assign mapped = ({1'b0, ptr_q} < MEM_LIMIT);
   end

   ibp_ptr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_lo (wr_en && (port_sel == SEL_PTR_LO)),
      .load_hi (wr_en && (port_sel == SEL_PTR_HI)),
      .clear   (data_wr),
      .din     (wr_data),
      .ptr_q   (ptr_q)
   );

   ibp_lock_ctrl #(
      .ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS),
      .LOCK_BASE(LOCK_BASE), .WIN_BYTES(WIN_BYTES)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .toggle     (lock_toggle),
      .ptr        (ptr_q),
      .lock_q     (lock_q),
      .sealed_hit (sealed_hit)
   );

   ibp_byte_store #(.MEM_BYTES(MEM_BYTES), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .we      (data_wr && mapped && !sealed_hit),
      .re      (data_rd && mapped && !sealed_hit),
      .idx     (ptr_q[IDX_W-1:0]),
      .wdata   (wr_data),
      .rdata_q (store_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     blank_q <= 1'b1;
      else if (rd_en) blank_q <= !(data_rd && mapped && !sealed_hit);
   end

   assign rd_data = blank_q ? '1 : store_q;

   // R4: sealed window reads return all ones
   p_sealed_read_ff_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && sealed_hit) |=> (rd_data == 8'hFF));
   // R6: unmapped reads return all ones
   p_unmapped_read_ff_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !mapped) |=> (rd_data == 8'hFF));
   // R3: output holds without a read; a read keeps the pointer
   p_rd_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   p_ptr_kept_on_read_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> $stable(ptr_q));
   // R7: spare offset reads return all ones
   p_spare_read_ff_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && port_sel != SEL_DATA) |=> (rd_data == 8'hFF));
endmodule

// File: tb/idx_byte_port_bench.sv
`timescale 1ns/1ps
module idx_byte_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] port_sel = 2'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [1:0] lock_toggle = 2'b00;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   idx_byte_port u_idx_byte_port (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .lock_toggle(lock_toggle), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      port_sel = sel; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [7:0] d);
      @(negedge clk);
      port_sel = sel; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic set_ptr(input logic [15:0] a);
      wr(2'd0, a[7:0]);
      wr(2'd1, a[15:8]);
   endtask

   task automatic poke(input logic [15:0] a, input logic [7:0] d);
      set_ptr(a);
      wr(2'd3, d);
   endtask

   task automatic peek(input logic [15:0] a, output logic [7:0] d);
      set_ptr(a);
      rd(2'd3, d);
   endtask

   task automatic toggle(input logic [1:0] t);
      @(negedge clk);
      lock_toggle = t;
      @(negedge clk);
      lock_toggle = 2'b00;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      check("R8 reset rd_data", rd_data, 8'hFF);
   endtask

   task automatic t_pointer();
      logic [7:0] v;
      poke(16'h0110, 8'h11);
      poke(16'h0210, 8'h22);
      peek(16'h0110, v);
      check("R1 both halves", v, 8'h11);
      wr(2'd1, 8'h02);
      rd(2'd3, v);
      check("R1 high half only", v, 8'h22);
      wr(2'd0, 8'h10);
      rd(2'd3, v);
      check("R1 low half only", v, 8'h22);
   endtask

   task automatic t_store_clear();
      logic [7:0] v;
      poke(16'h0000, 8'h5A);
      poke(16'h0055, 8'h77);
      rd(2'd3, v);
      check("R2 pointer cleared", v, 8'h5A);
      peek(16'h0055, v);
      check("R2 stored byte", v, 8'h77);
   endtask

   task automatic t_read_hold();
      logic [7:0] v;
      peek(16'h0055, v);
      repeat (3) @(negedge clk);
      check("R3 hold", rd_data, 8'h77);
      rd(2'd3, v);
      check("R3 pointer kept by read", v, 8'h77);
   endtask

   task automatic t_locks();
      logic [7:0] v;
      poke(16'h001F, 8'h1F);
      poke(16'h0025, 8'hC1);
      poke(16'h0035, 8'hC2);
      poke(16'h0040, 8'h44);
      poke(16'h0030, 8'h30);
      toggle(2'b01);
      peek(16'h0025, v);
      check("R4 sealed window 0 read", v, 8'hFF);
      peek(16'h0035, v);
      check("R4 window 1 open", v, 8'hC2);
      poke(16'h0025, 8'h99);
      toggle(2'b01);
      peek(16'h0025, v);
      check("R5 unsealed, R4 store dropped", v, 8'hC1);
      toggle(2'b10);
      peek(16'h0030, v);
      check("R4 window 1 low edge", v, 8'hFF);
      peek(16'h0035, v);
      check("R4 window 1 sealed", v, 8'hFF);
      peek(16'h0040, v);
      check("R4 above window", v, 8'h44);
      peek(16'h001F, v);
      check("R4 below window", v, 8'h1F);
      peek(16'h0025, v);
      check("R4 window 0 open", v, 8'hC1);
      toggle(2'b10);
      peek(16'h0030, v);
      check("R5 window 1 unsealed", v, 8'h30);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      poke(16'h03FF, 8'h3C);
      poke(16'h0400, 8'hEE);
      peek(16'h0400, v);
      check("R6 unmapped read", v, 8'hFF);
      peek(16'h0000, v);
      check("R6 no alias", v, 8'h5A);
      peek(16'h03FF, v);
      check("R6 last byte", v, 8'h3C);
   endtask

   task automatic t_spare();
      logic [7:0] v;
      set_ptr(16'h0055);
      wr(2'd2, 8'h99);
      rd(2'd3, v);
      check("R7 spare write ignored", v, 8'h77);
      rd(2'd0, v);
      check("R7 read offset 0", v, 8'hFF);
      rd(2'd1, v);
      check("R7 read offset 1", v, 8'hFF);
      rd(2'd2, v);
      check("R7 read offset 2", v, 8'hFF);
   endtask

   task automatic t_reset_keeps();
      logic [7:0] v;
      toggle(2'b01);
      set_ptr(16'h0055);
      do_reset();
      rd(2'd3, v);
      check("R8 pointer cleared", v, 8'h5A);
      peek(16'h0025, v);
      check("R8 seals cleared, memory kept", v, 8'hC1);
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_pointer();
      t_store_clear();
      t_read_hold();
      t_locks();
      t_unmapped();
      t_spare();
      t_reset_keeps();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule